// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

A small processor uses this peripheral through a plain register read/write bus. It provides a 16x16 multiplier with a 48-bit accumulator. Software loads two operand registers. Each operand write is counted, and when enough writes have been seen, the operation selected in the control register is started. The possible operations are product, accumulate, negated product, subtract from accumulator, and square. One clock edge later the result sits in the three accumulator words. During that one cycle a busy status bit is high.

Several control bits change how the unit behaves:
- One bit picks a trigger on a single operand write instead of a trigger on both operands.
- One bit turns a single operand write into a square.
- One bit keeps the accumulator unchanged so that only the overflow flag is updated.
- One bit chooses signed or unsigned arithmetic.
- A self-clearing command wipes all data registers and the overflow flag, including an operation that has started but not yet finished.

Register map (word addresses): 0 control, 1 operand A, 2 operand B, 3/4/5 accumulator words from least to most significant, 6 status. Address 7 reads as zero.

Top module: `mac_periph`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads 0000h.
- R2: Control bits [1:0] select the operation: 00 stores A*B, 01 adds A*B to the accumulator, 10 stores -(A*B), 11 subtracts A*B from the accumulator. The accumulator is word 5 : word 4 : word 3, with word 5 most significant.
- R3: With control bit 2 at 0, an operation starts only when both A and B have been written since the last start or clear. A second write to the same operand does not start one.
- R4: With control bit 2 at 1, any write to A or B starts an operation.
- R5: With control bit 3 at 1, a write to A or B loads the value into both operands and starts a square, whatever the value of bit 2.
- R6: Writing 1 to control bit 4 zeroes both operands, the accumulator, the overflow flag and the operand-write tracking. Bit 4 always reads 0. A control write with bit 4 at 0 leaves all data registers unchanged.
- R7: A clear written in the cycle while an operation is pending aborts it. Afterwards all data registers and the overflow flag read zero.
- R8: With control bit 5 at 1, the result is discarded and the accumulator keeps its value. The overflow flag is still updated from the discarded result.
- R9: Control bit 6 selects two's-complement operands (1) or unsigned operands (0). The 32-bit product is sign-extended or zero-extended before it is combined with the accumulator.
- R10: Control bit 7 is a read-only overflow flag. It is set when the exact result lies outside the 48-bit range for the selected signedness, while the accumulator keeps the result modulo 2^48. It reads 0 from the start of each operation until its result is produced.
- R11: Status bit 0 (address 6) is 1 in exactly the one cycle after a starting write. After that cycle the result is readable.
- R12: Control bits 15:8 ignore writes and read 0. The register at address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the register at addr (combinational) |

## Verification
The assertions assume that software does not write an operand or an accumulator word during the single busy cycle. The only write allowed in that cycle is a clear. This means a busy pulse always ends after one cycle, and the accumulator is never a target for the bus and the result at the same edge. The random stimulus follows this rule: after every write it waits one idle cycle and reads back every register. The only write placed inside a busy cycle is the directed abort case.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // register word indices on the bus
  localparam int CTRL_IDX = 0;
  localparam int OPA_IDX  = 1;
  localparam int OPB_IDX  = 2;
  localparam int ACC_IDX  = 3;

  // control register bit positions
  localparam int CB_ACC    = 0;
  localparam int CB_NEG    = 1;
  localparam int CB_SINGLE = 2;
  localparam int CB_SQUARE = 3;
  localparam int CB_CLEAR  = 4;
  localparam int CB_HOLD   = 5;
  localparam int CB_SIGNED = 6;
  localparam int CB_OVF    = 7;
  localparam int MODE_W    = 7;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_NEG  = 2'b10,
    OP_MSUB = 2'b11
  } macOpE;

  typedef struct packed {
    logic  loadA;
    logic  loadB;
    logic  clearAll;
    logic  startOp;
    logic  compute;
    macOpE op;
    logic  signedOp;
    logic  holdRes;
  } macStrobeT;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int ACC_WORDS = 3,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [MODE_W-1:0]    ctrlData,
  output macStrobeT            stb,
  output logic [ACC_WORDS-1:0] loadAcc,
  output logic [MODE_W-1:0]    modeBits,
  output logic                 busy
);

  logic [MODE_W-1:0] modeQ;
  logic              seenAQ, seenBQ, busyQ;
  macOpE             opQ;
  logic              sgnQ, holdQ;

  logic ctrlWr, clearReq, wrA, wrB, opWr, sqMode, singleMode, trig;

  always_comb begin
    ctrlWr     = wrEn && (addr == ADDR_W'(CTRL_IDX));
    clearReq   = ctrlWr && ctrlData[CB_CLEAR];
    wrA        = wrEn && (addr == ADDR_W'(OPA_IDX));
    wrB        = wrEn && (addr == ADDR_W'(OPB_IDX));
    opWr       = wrA || wrB;
    sqMode     = modeQ[CB_SQUARE];
    singleMode = modeQ[CB_SINGLE];
    trig       = opWr && (sqMode || singleMode || (wrA && seenBQ) || (wrB && seenAQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      seenAQ <= 1'b0;
      seenBQ <= 1'b0;
      busyQ  <= 1'b0;
      opQ    <= OP_MUL;
      sgnQ   <= 1'b0;
      holdQ  <= 1'b0;
    end else if (clearReq) begin
      modeQ  <= ctrlData & ~(MODE_W'(1) << CB_CLEAR);
      seenAQ <= 1'b0;
      seenBQ <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      if (ctrlWr) modeQ <= ctrlData;
      if (trig) begin
        seenAQ <= 1'b0;
        seenBQ <= 1'b0;
        busyQ  <= 1'b1;
        opQ    <= macOpE'(modeQ[CB_NEG:CB_ACC]);
        sgnQ   <= modeQ[CB_SIGNED];
        holdQ  <= modeQ[CB_HOLD];
      end else begin
        busyQ <= 1'b0;
        if (wrA) seenAQ <= 1'b1;
        if (wrB) seenBQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.loadA    = wrA || (sqMode && wrB);
    stb.loadB    = wrB || (sqMode && wrA);
    stb.clearAll = clearReq;
    stb.startOp  = trig;
    stb.compute  = busyQ;
    stb.op       = opQ;
    stb.signedOp = sgnQ;
    stb.holdRes  = holdQ;
  end

  for (genvar i = 0; i < ACC_WORDS; i++) begin : g_accSel
    assign loadAcc[i] = wrEn && (addr == ADDR_W'(ACC_IDX + i));
  end

  assign modeBits = modeQ;
  assign busy     = busyQ;

  // R11
  busy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !trig) |=> !busyQ);

  // R3
  two_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opWr && !sqMode && !singleMode && !seenAQ && !seenBQ && !clearReq) |=> !busyQ);

  // R5
  square_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opWr && sqMode) |-> (stb.loadA && stb.loadB && stb.startOp));

  // R6
  clear_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (!busyQ && !seenAQ && !seenBQ && !modeQ[CB_CLEAR]));

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  macStrobeT                   stb,
  input  logic [ACC_WORDS-1:0]        loadAcc,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           opA,
  output logic [DATA_W-1:0]           opB,
  output logic [DATA_W*ACC_WORDS-1:0] acc,
  output logic                        ovf
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = DATA_W * ACC_WORDS;
  localparam int EXT_W  = ACC_W + 2;

  logic [DATA_W-1:0] opAQ, opBQ;
  logic [ACC_W-1:0]  accQ;
  logic              ovfQ;

  logic [PROD_W-1:0]        prodU;
  logic signed [PROD_W-1:0] prodS;
  logic [EXT_W-1:0]         prodExt, accExt, resExt;
  logic                     ovfCalc;

  always_comb begin
    prodU = PROD_W'(opAQ) * PROD_W'(opBQ);
    prodS = PROD_W'($signed(opAQ)) * PROD_W'($signed(opBQ));
    if (stb.signedOp) begin
      prodExt = {{(EXT_W-PROD_W){prodS[PROD_W-1]}}, prodS};
      accExt  = {{2{accQ[ACC_W-1]}}, accQ};
    end else begin
      prodExt = {{(EXT_W-PROD_W){1'b0}}, prodU};
      accExt  = {2'b00, accQ};
    end
    unique case (stb.op)
      OP_MUL:  resExt = prodExt;
      OP_MAC:  resExt = accExt + prodExt;
      OP_NEG:  resExt = '0 - prodExt;
      OP_MSUB: resExt = accExt - prodExt;
      default: resExt = prodExt;
    endcase
    if (stb.signedOp)
      ovfCalc = (resExt[EXT_W-1:ACC_W-1] != '0) && (resExt[EXT_W-1:ACC_W-1] != '1);
    else
      ovfCalc = (resExt[EXT_W-1:ACC_W] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ <= '0;
      opBQ <= '0;
      accQ <= '0;
      ovfQ <= 1'b0;
    end else if (stb.clearAll) begin
      opAQ <= '0;
      opBQ <= '0;
      accQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (stb.loadA) opAQ <= wrData;
      if (stb.loadB) opBQ <= wrData;
      for (int i = 0; i < ACC_WORDS; i++)
        if (loadAcc[i]) accQ[i*DATA_W +: DATA_W] <= wrData;
      if (stb.startOp) ovfQ <= 1'b0;
      if (stb.compute) begin
        ovfQ <= ovfCalc;
        if (!stb.holdRes) accQ <= resExt[ACC_W-1:0];
      end
    end
  end

  assign opA = opAQ;
  assign opB = opBQ;
  assign acc = accQ;
  assign ovf = ovfQ;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (opAQ == '0 && opBQ == '0 && accQ == '0 && !ovfQ));

  // R8
  hold_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.compute && stb.holdRes && !stb.clearAll && loadAcc == '0) |=> $stable(accQ));

  // R2
  mul_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.compute && stb.op == OP_MUL && !stb.signedOp && !stb.holdRes && !stb.clearAll)
      |=> accQ == ACC_W'($past(opAQ)) * ACC_W'($past(opBQ)));

  // R10
  ovf_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startOp && !stb.compute) |=> !ovfQ);

endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int ACC_WORDS = 3,
  localparam int ADDR_W    = $clog2(ACC_IDX + ACC_WORDS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int STAT_IDX = ACC_IDX + ACC_WORDS;
  localparam int ACC_W    = DATA_W * ACC_WORDS;

  macStrobeT            stb;
  logic [ACC_WORDS-1:0] loadAcc;
  logic [MODE_W-1:0]    modeBits;
  logic                 busy, ovf;
  logic [DATA_W-1:0]    opA, opB;
  logic [ACC_W-1:0]     acc;

  mac_ctrl #(.ACC_WORDS(ACC_WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .ctrlData (wrData[MODE_W-1:0]),
    .stb      (stb),
    .loadAcc  (loadAcc),
    .modeBits (modeBits),
    .busy     (busy)
  );

  mac_datapath #(.DATA_W(DATA_W), .ACC_WORDS(ACC_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .loadAcc (loadAcc),
    .wrData  (wrData),
    .opA     (opA),
    .opB     (opB),
    .acc     (acc),
    .ovf     (ovf)
  );

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(CTRL_IDX)) begin
      rdData[MODE_W-1:0] = modeBits;
      rdData[CB_OVF]     = ovf;
    end else if (addr == ADDR_W'(OPA_IDX)) begin
      rdData = opA;
    end else if (addr == ADDR_W'(OPB_IDX)) begin
      rdData = opB;
    end else if (addr == ADDR_W'(STAT_IDX)) begin
      rdData[0] = busy;
    end
    for (int i = 0; i < ACC_WORDS; i++)
      if (addr == ADDR_W'(ACC_IDX + i)) rdData = acc[i*DATA_W +: DATA_W];
  end

endmodule

// File: tb/mac_periph_tb.sv
module mac_periph_tb;

  localparam int CLK_PERIOD = 10;
  localparam longint LIM47 = longint'(1) << 47;
  localparam longint LIM48 = longint'(1) << 48;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_periph u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic [15:0] mA, mB;
  logic [47:0] mAcc;
  logic        mOvf, mSeenA, mSeenB, mPend, pSgn, pHold;
  logic [6:0]  mMode;
  logic [1:0]  pOp;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void refCalc(input logic [1:0] op, input logic sgn, input logic [15:0] a,
                                  input logic [15:0] b, input logic [47:0] ac,
                                  output logic [47:0] res, output logic ov);
    longint pa, pb, pc, p, r;
    if (sgn) begin
      pa = longint'($signed(a)); pb = longint'($signed(b)); pc = longint'($signed(ac));
    end else begin
      pa = longint'(a); pb = longint'(b); pc = longint'(ac);
    end
    p = pa * pb;
    case (op)
      2'b00: r = p;
      2'b01: r = pc + p;
      2'b10: r = -p;
      default: r = pc - p;
    endcase
    ov  = sgn ? (r >= LIM47 || r < -LIM47) : (r < 0 || r >= LIM48);
    res = r[47:0];
  endfunction

  task automatic modelIdle();
    logic [47:0] res;
    logic ov;
    if (mPend) begin
      refCalc(pOp, pSgn, mA, mB, mAcc, res, ov);
      mOvf = ov;
      if (!pHold) mAcc = res;
      mPend = 1'b0;
    end
  endtask

  task automatic modelWrite(input logic [2:0] a, input logic [15:0] d, output bit trig);
    trig = 1'b0;
    modelIdle();
    case (a)
      3'd0: begin
        mMode = d[6:0] & 7'h6F;
        if (d[4]) begin
          mA = '0; mB = '0; mAcc = '0; mOvf = 1'b0; mSeenA = 1'b0; mSeenB = 1'b0;
        end
      end
      3'd1, 3'd2: begin
        trig = mMode[3] || mMode[2] || (a == 3'd1 && mSeenB) || (a == 3'd2 && mSeenA);
        if (mMode[3]) begin mA = d; mB = d; end
        else if (a == 3'd1) mA = d;
        else mB = d;
        if (trig) begin
          mSeenA = 1'b0; mSeenB = 1'b0; mOvf = 1'b0; mPend = 1'b1;
          pOp = mMode[1:0]; pSgn = mMode[6]; pHold = mMode[5];
        end else if (a == 3'd1) mSeenA = 1'b1;
        else mSeenB = 1'b1;
      end
      3'd3: mAcc[15:0]  = d;
      3'd4: mAcc[31:16] = d;
      3'd5: mAcc[47:32] = d;
      default: ;
    endcase
  endtask

  // called at a falling edge; returns at the falling edge after the capturing edge
  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readNow(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    readNow(a, v);
  endtask

  task automatic checkAll(input string req);
    logic [15:0] v;
    readReg(3'd0, v); check(req, "ctrl", v, {8'h00, mOvf, mMode});
    readReg(3'd1, v); check(req, "opA", v, mA);
    readReg(3'd2, v); check(req, "opB", v, mB);
    readReg(3'd3, v); check(req, "acc0", v, mAcc[15:0]);
    readReg(3'd4, v); check(req, "acc1", v, mAcc[31:16]);
    readReg(3'd5, v); check(req, "acc2", v, mAcc[47:32]);
    readReg(3'd6, v); check(req, "status", v, 16'h0000);
    readReg(3'd7, v); check(req, "addr7", v, 16'h0000);
  endtask

  // one write, then the R11 busy check, then a full read-back
  task automatic doOp(input string req, input logic [2:0] a, input logic [15:0] d);
    bit trig;
    logic [15:0] v;
    modelWrite(a, d, trig);
    busWrite(a, d);
    readNow(3'd6, v);
    check({req, " R11"}, "busy", v, {15'h0, trig});
    modelIdle();
    checkAll(req);
  endtask

  function automatic logic [15:0] pickData();
    case ($urandom % 6)
      0: return 16'hFFFF;
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    mA = '0; mB = '0; mAcc = '0; mOvf = 1'b0; mSeenA = 1'b0; mSeenB = 1'b0;
    mPend = 1'b0; pSgn = 1'b0; pHold = 1'b0; mMode = '0; pOp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    checkAll("R1 reset");

    // R2 R3: unsigned product on two writes
    doOp("R2", 3'd0, 16'h0000);
    doOp("R3 first write", 3'd1, 16'd3);
    doOp("R3 repeat write", 3'd1, 16'd4);
    doOp("R2 product", 3'd2, 16'd5);
    // R2 accumulate
    doOp("R2", 3'd0, 16'h0001);
    doOp("R2", 3'd1, 16'd2);
    doOp("R2 accumulate", 3'd2, 16'd7);
    // R4 single-write subtract
    doOp("R4", 3'd0, 16'h0007);
    doOp("R4 subtract", 3'd1, 16'd1);
    // R10 unsigned negate overflows, then a new start clears the flag
    doOp("R10", 3'd0, 16'h0006);
    doOp("R10 negate ovf", 3'd2, 16'd2);
    doOp("R10", 3'd0, 16'h0004);
    doOp("R10 ovf cleared", 3'd1, 16'd0);
    // R5 R9 square, signed and unsigned, with bit 2 set or clear
    doOp("R5", 3'd0, 16'h004C);
    doOp("R5 R9 signed square", 3'd2, 16'hFFFF);
    doOp("R5", 3'd0, 16'h0008);
    doOp("R5 R9 unsigned square", 3'd1, 16'hFFFF);
    // R8 hold keeps the accumulator
    doOp("R8", 3'd0, 16'h0024);
    doOp("R8 hold", 3'd1, 16'd9);
    // R9 R10 signed accumulate overflow with wrap
    doOp("R6", 3'd0, 16'h0051);
    doOp("R9", 3'd3, 16'hFFFF);
    doOp("R9", 3'd4, 16'hFFFF);
    doOp("R9", 3'd5, 16'h7FFF);
    doOp("R9", 3'd1, 16'h7FFF);
    doOp("R10 signed ovf", 3'd2, 16'h7FFF);
    // R7 clear in the busy cycle aborts
    doOp("R7", 3'd0, 16'h0004);
    doOp("R7", 3'd3, 16'h1234);
    begin
      bit trig;
      modelWrite(3'd1, 16'd5, trig);
      busWrite(3'd1, 16'd5);
      readNow(3'd6, v);
      check("R7 R11", "busy before abort", v, 16'h0001);
      modelWrite(3'd0, 16'h0010, trig);
      busWrite(3'd0, 16'h0010);
      checkAll("R7 abort");
    end
    // R6 writing 0 to the clear bit keeps data; a clear resets tracking
    doOp("R6", 3'd1, 16'd4);
    doOp("R6 no clear", 3'd0, 16'h0000);
    doOp("R6 clear", 3'd0, 16'h0010);
    doOp("R6 tracking reset", 3'd2, 16'd3);
    // R12 reserved bits
    doOp("R12", 3'd0, 16'hFF01);
    readReg(3'd0, v);
    check("R12", "reserved", v & 16'hFF00, 16'h0000);
    doOp("R12 addr7 write", 3'd7, 16'hFFFF);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [15:0] d;
      r = int'($urandom % 10);
      if (r < 2) begin
        d = 16'($urandom);
        if (($urandom % 8) != 0) d[4] = 1'b0;
        doOp("R2 R9 R10 random ctrl", 3'd0, d);
      end else if (r < 8) begin
        doOp("R2 R3 R4 R5 random operand", (($urandom % 2) == 0) ? 3'd1 : 3'd2, pickData());
      end else begin
        doOp("R2 random acc", 3'(3 + ($urandom % 3)), pickData());
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule